// File: doc/BRIEF.md
# Gateway Branch Privilege Promotion Unit

This unit decodes and executes a gateway branch: a PC-relative branch that can raise the privilege of the code it jumps to. The processor keeps a two-entry queue of instruction addresses, a front entry and a back entry. The low two bits of every address hold the privilege level, and a smaller number means more privilege. On each strobed instruction word the unit makes one of three decisions:

- take the branch, producing a target whose privilege field may be promoted from the instruction page's access type, plus an optional link-register write and a nullify request;
- reject the word as illegal;
- request an instruction-TLB refill.

The unit sits beside the branch stage. The stage presents the instruction, the queue state, the current privilege, the code-translation enable and the page lookup result, all together with a one-cycle valid strobe. One clock later a registered result appears for one cycle. The TLB, the register file and the pipeline sit outside the unit.

Top module: `gate_branch_unit`

## Requirements
- R1: A word is recognised only when `(instr & 32'hFC00E000) == 32'hE8002000` while `inValid` is high. A recognised word produces a one-cycle `outValid` pulse on the clock edge after the strobe. Any other word produces no output activity.
- R2: The nullify request is taken from `instr[1]` and the link index from `instr[25:21]`. The 17-bit signed word offset is `{instr[0], instr[20:16], instr[12:2]}`, with `instr[0]` as its sign bit.
- R3: A taken branch targets `addrFront + 8 + 4*offset`, with bits [1:0] replaced by the current privilege before any promotion.
- R4: The word is illegal when `backKnown` is low or when `addrBack != addrFront + 4`. In that case only `excIllegal` is raised: no branch, no link write and no nullify. This check takes precedence over R5.
- R5: With `xlateOn` high and `pageHit` low, only `excTlbMiss` is raised. There is no branch and no link write.
- R6: With `xlateOn` and `pageHit` high and `pageType` in 4..7, the target bits [1:0] become `pageType-4` when that value is numerically below `curPriv`.
- R7: With `xlateOn` high, the target keeps `curPriv` in bits [1:0] when `pageType` is below 4 or when `pageType-4 >= curPriv`.
- R8: With `xlateOn` low, the target bits [1:0] are forced to 0, and `pageHit` and `pageType` have no effect. In particular, no TLB miss is raised.
- R9: A taken branch writes `linkData = (addrBack + 4)` with bits [1:0] equal to `curPriv` to register `linkIdx`. No write (`linkWrite` low) is made when the index is 0.
- R10: After reset and in every cycle without a recognised strobe, all outputs are 0. With `outValid` high, exactly one of `branchTaken`, `excIllegal` and `excTlbMiss` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input strobe |
| instr | input | 32 | Instruction word |
| addrFront | input | 32 | Front queue address, privilege in [1:0] |
| addrBack | input | 32 | Back queue address, privilege in [1:0] |
| backKnown | input | 1 | Back address is valid |
| xlateOn | input | 1 | Code translation enabled |
| curPriv | input | 2 | Current privilege level |
| pageHit | input | 1 | Instruction page lookup hit |
| pageType | input | 3 | Page access type |
| outValid | output | 1 | Result valid (one cycle) |
| branchTaken | output | 1 | Branch is taken |
| branchTarget | output | 32 | Target with privilege in [1:0] |
| nullify | output | 1 | Nullify next instruction |
| linkWrite | output | 1 | Link register write enable |
| linkIdx | output | 5 | Link register index |
| linkData | output | 32 | Return address written to the link register |
| excIllegal | output | 1 | Illegal instruction exception |
| excTlbMiss | output | 1 | Instruction TLB miss exception |

## Verification
The assertions treat `curPriv`, `xlateOn` and the page inputs as known values on every clock edge, because they look at the previous cycle's inputs whether or not a strobe was present. The bench drives all inputs at the falling edge and holds them at defined values between strobes. It keeps the queue address's privilege field equal to `curPriv`, since the design does not check that the two agree. It sweeps every combination of translation enable, privilege, hit and access type. It varies the offset sign, the link index and the nullify bit across the sweep.

// File: rtl/gate_branch_pkg.sv
package gate_branch_pkg;
  localparam int INSTR_W = 32;
  localparam int PRIV_W = 2;
  localparam int LINK_W = 5;
  localparam int OFF_W = 17;
  localparam int TYPE_W = 3;
  localparam logic [INSTR_W-1:0] GATE_MASK = 32'hFC00E000;
  localparam logic [INSTR_W-1:0] GATE_MATCH = 32'hE8002000;

  // Strobes from control to datapath
  typedef struct packed {
    logic recognised;
    logic taken;
    logic illegal;
    logic tlbMiss;
    logic promote;
    logic forceZero;
    logic linkEn;
    logic nullifyReq;
  } ctrlStrobes_t;
endpackage

// File: rtl/gate_branch_ctrl.sv
module gate_branch_ctrl
  import gate_branch_pkg::*;
(
  input  logic                inValid,
  input  logic [INSTR_W-1:0]  instr,
  input  logic                backKnown,
  input  logic                seqOk,
  input  logic                xlateOn,
  input  logic [PRIV_W-1:0]   curPriv,
  input  logic                pageHit,
  input  logic [TYPE_W-1:0]   pageType,
  output ctrlStrobes_t        strobes
);
  logic isGate;
  logic queueBad;
  logic missNow;
  logic gatewayPage;
  logic raises;

  assign isGate      = inValid && ((instr & GATE_MASK) == GATE_MATCH);
  assign queueBad    = !backKnown || !seqOk;
  assign missNow     = xlateOn && !pageHit;
  assign gatewayPage = pageType[TYPE_W-1];
  assign raises      = pageType[PRIV_W-1:0] < curPriv;

  always_comb begin
    strobes = '0;
    strobes.recognised = isGate;
    if (isGate) begin
      if (queueBad) begin
        strobes.illegal = 1'b1;
      end else if (missNow) begin
        strobes.tlbMiss = 1'b1;
      end else begin
        strobes.taken      = 1'b1;
        strobes.forceZero  = !xlateOn;
        strobes.promote    = xlateOn && gatewayPage && raises;
        strobes.linkEn     = instr[25:21] != '0;
        strobes.nullifyReq = instr[1];
      end
    end
  end
endmodule

// File: rtl/gate_branch_datapath.sv
module gate_branch_datapath
  import gate_branch_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [INSTR_W-1:0]  instr,
  input  logic [ADDR_W-1:0]   addrFront,
  input  logic [ADDR_W-1:0]   addrBack,
  input  logic                xlateOn,
  input  logic [PRIV_W-1:0]   curPriv,
  input  logic                pageHit,
  input  logic [TYPE_W-1:0]   pageType,
  output logic                seqOk,
  output logic                outValid,
  output logic                branchTaken,
  output logic [ADDR_W-1:0]   branchTarget,
  output logic                nullify,
  output logic                linkWrite,
  output logic [LINK_W-1:0]   linkIdx,
  output logic [ADDR_W-1:0]   linkData,
  output logic                excIllegal,
  output logic                excTlbMiss
);
  localparam int EXT_W = ADDR_W - OFF_W - 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] FWD2 = ADDR_W'(8);

  logic [OFF_W-1:0]  offWord;
  logic [ADDR_W-1:0] dispBytes;
  logic [ADDR_W-1:0] rawTarget;
  logic [ADDR_W-1:0] retAddr;
  logic [PRIV_W-1:0] tgtPriv;
  logic [ADDR_W-1:0] nextTarget;
  logic [ADDR_W-1:0] nextLink;

  assign seqOk     = addrBack == (addrFront + STEP);
  assign offWord   = {instr[0], instr[20:16], instr[12:2]};
  assign dispBytes = {{EXT_W{offWord[OFF_W-1]}}, offWord, 2'b00};
  assign rawTarget = addrFront + FWD2 + dispBytes;
  assign retAddr   = addrBack + STEP;

  always_comb begin
    tgtPriv = curPriv;
    if (strobes.forceZero) tgtPriv = '0;
    else if (strobes.promote) tgtPriv = pageType[PRIV_W-1:0];
  end

  assign nextTarget = {rawTarget[ADDR_W-1:PRIV_W], tgtPriv};
  assign nextLink   = {retAddr[ADDR_W-1:PRIV_W], curPriv};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      branchTaken  <= 1'b0;
      branchTarget <= '0;
      nullify      <= 1'b0;
      linkWrite    <= 1'b0;
      linkIdx      <= '0;
      linkData     <= '0;
      excIllegal   <= 1'b0;
      excTlbMiss   <= 1'b0;
    end else begin
      outValid     <= strobes.recognised;
      branchTaken  <= strobes.taken;
      branchTarget <= strobes.taken ? nextTarget : '0;
      nullify      <= strobes.nullifyReq;
      linkWrite    <= strobes.linkEn;
      linkIdx      <= strobes.linkEn ? instr[25:21] : '0;
      linkData     <= strobes.linkEn ? nextLink : '0;
      excIllegal   <= strobes.illegal;
      excTlbMiss   <= strobes.tlbMiss;
    end
  end

  // R10: a valid result carries exactly one outcome
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $countones({branchTaken, excIllegal, excTlbMiss}) == 1);
  // R10: quiet when no result
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !(branchTaken || excIllegal || excTlbMiss || linkWrite || nullify));
  // R4/R5: faults produce no link write or nullify
  a_r4_fault_silent: assert property (@(posedge clk) disable iff (!rstN)
    (excIllegal || excTlbMiss) |-> !(linkWrite || nullify || branchTaken));
  // R5: a miss needs translation on and a lookup miss
  a_r5_miss_cause: assert property (@(posedge clk) disable iff (!rstN)
    excTlbMiss |-> $past(xlateOn && !pageHit));
  // R8: translation off gives privilege 0
  a_r8_force_zero: assert property (@(posedge clk) disable iff (!rstN)
    (branchTaken && !$past(xlateOn)) |-> branchTarget[PRIV_W-1:0] == '0);
  // R6/R7: privilege never lowered by the branch
  a_r7_no_demote: assert property (@(posedge clk) disable iff (!rstN)
    (branchTaken && $past(xlateOn)) |-> branchTarget[PRIV_W-1:0] <= $past(curPriv));
  // R9: link write needs a taken branch and nonzero index
  a_r9_link_gate: assert property (@(posedge clk) disable iff (!rstN)
    linkWrite |-> (branchTaken && linkIdx != '0));
  // R9: return address keeps the current privilege
  a_r9_link_priv: assert property (@(posedge clk) disable iff (!rstN)
    linkWrite |-> linkData[PRIV_W-1:0] == $past(curPriv));
endmodule

// File: rtl/gate_branch_unit.sv
module gate_branch_unit
  import gate_branch_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [INSTR_W-1:0]  instr,
  input  logic [ADDR_W-1:0]   addrFront,
  input  logic [ADDR_W-1:0]   addrBack,
  input  logic                backKnown,
  input  logic                xlateOn,
  input  logic [PRIV_W-1:0]   curPriv,
  input  logic                pageHit,
  input  logic [TYPE_W-1:0]   pageType,
  output logic                outValid,
  output logic                branchTaken,
  output logic [ADDR_W-1:0]   branchTarget,
  output logic                nullify,
  output logic                linkWrite,
  output logic [LINK_W-1:0]   linkIdx,
  output logic [ADDR_W-1:0]   linkData,
  output logic                excIllegal,
  output logic                excTlbMiss
);
  ctrlStrobes_t strobes;
  logic seqOk;

  gate_branch_ctrl u_ctrl (
    .inValid  (inValid),
    .instr    (instr),
    .backKnown(backKnown),
    .seqOk    (seqOk),
    .xlateOn  (xlateOn),
    .curPriv  (curPriv),
    .pageHit  (pageHit),
    .pageType (pageType),
    .strobes  (strobes)
  );

  gate_branch_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .instr       (instr),
    .addrFront   (addrFront),
    .addrBack    (addrBack),
    .xlateOn     (xlateOn),
    .curPriv     (curPriv),
    .pageHit     (pageHit),
    .pageType    (pageType),
    .seqOk       (seqOk),
    .outValid    (outValid),
    .branchTaken (branchTaken),
    .branchTarget(branchTarget),
    .nullify     (nullify),
    .linkWrite   (linkWrite),
    .linkIdx     (linkIdx),
    .linkData    (linkData),
    .excIllegal  (excIllegal),
    .excTlbMiss  (excTlbMiss)
  );
endmodule

// File: tb/test_gate_branch_unit.sv
module test_gate_branch_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] addrFront = '0;
  logic [31:0] addrBack = '0;
  logic backKnown = 1'b0;
  logic xlateOn = 1'b0;
  logic [1:0] curPriv = '0;
  logic pageHit = 1'b0;
  logic [2:0] pageType = '0;
  logic outValid, branchTaken, nullify, linkWrite, excIllegal, excTlbMiss;
  logic [31:0] branchTarget, linkData;
  logic [4:0] linkIdx;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  gate_branch_unit i_gate_branch_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr),
    .addrFront(addrFront), .addrBack(addrBack), .backKnown(backKnown),
    .xlateOn(xlateOn), .curPriv(curPriv), .pageHit(pageHit), .pageType(pageType),
    .outValid(outValid), .branchTaken(branchTaken), .branchTarget(branchTarget),
    .nullify(nullify), .linkWrite(linkWrite), .linkIdx(linkIdx), .linkData(linkData),
    .excIllegal(excIllegal), .excTlbMiss(excTlbMiss)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkInstr(bit n, int link, int off);
    logic [16:0] o;
    o = 17'(off);
    return 32'hE8002000 | (32'(link) << 21) | (32'(n) << 1)
           | (32'(o[16])) | (32'(o[15:11]) << 16) | (32'(o[10:0]) << 2);
  endfunction

  task automatic checkAll(string req, bit eV, bit eT, bit eI, bit eM,
                          logic [31:0] eTgt, bit eN, bit eW, int eIdx,
                          logic [31:0] eLink);
    chk(req, "outValid", 32'(outValid), 32'(eV));
    chk(req, "branchTaken", 32'(branchTaken), 32'(eT));
    chk(req, "excIllegal", 32'(excIllegal), 32'(eI));
    chk(req, "excTlbMiss", 32'(excTlbMiss), 32'(eM));
    chk(req, "branchTarget", branchTarget, eTgt);
    chk(req, "nullify", 32'(nullify), 32'(eN));
    chk(req, "linkWrite", 32'(linkWrite), 32'(eW));
    chk(req, "linkIdx", 32'(linkIdx), 32'(eIdx));
    chk(req, "linkData", linkData, eLink);
  endtask

  // Drive one strobe and compare the registered result with the model
  task automatic run(string req, logic [31:0] w, logic [31:0] fr, logic [31:0] bk,
                     bit bkn, bit x, int p, bit h, int ty);
    bit match, ill, miss, tk, n, lw;
    int idx, off, np;
    logic [31:0] tgt, lnk;
    @(negedge clk);
    instr = w; addrFront = fr; addrBack = bk; backKnown = bkn;
    xlateOn = x; curPriv = 2'(p); pageHit = h; pageType = 3'(ty); inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    match = (w & 32'hFC00E000) == 32'hE8002000;
    ill = match && (!bkn || bk != fr + 32'd4);
    miss = match && !ill && x && !h;
    tk = match && !ill && !miss;
    idx = int'(w[25:21]);
    n = w[1];
    off = int'(w[20:16]) * 2048 + int'(w[12:2]) - (w[0] ? 65536 : 0);
    np = p;
    if (!x) np = 0;
    else if (ty >= 4 && ty - 4 < p) np = ty - 4;
    tgt = fr + 32'(8 + off * 4);
    tgt = (tgt & ~32'd3) | 32'(np);
    lnk = ((bk + 32'd4) & ~32'd3) | 32'(p);
    lw = tk && idx != 0;
    checkAll(req, match, tk, ill, miss, tk ? tgt : 32'd0, tk && n, lw,
             lw ? idx : 0, lw ? lnk : 32'd0);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    checkAll("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    rstN = 1'b1;

    // Full sweep over translation, privilege, hit and access type
    for (int x = 0; x < 2; x++)
      for (int p = 0; p < 4; p++)
        for (int h = 0; h < 2; h++)
          for (int ty = 0; ty < 8; ty++) begin
            int it;
            int off;
            logic [31:0] fr;
            string tag;
            it = ((x * 4 + p) * 2 + h) * 8 + ty;
            off = ((it * 1013) % 131072) - 65536;
            fr = 32'h4000_0000 + 32'(it * 256) + 32'(p);
            if (x == 0) tag = "R8";
            else if (h == 0) tag = "R5";
            else if (ty >= 4 && ty - 4 < p) tag = "R6";
            else tag = "R7";
            run(tag, mkInstr(bit'(it % 2), it % 32, off), fr, fr + 32'd4, 1, bit'(x), p, bit'(h), ty);
          end

    // R2, R3: field extraction and target arithmetic at offset extremes
    run("R3", mkInstr(1, 7, 65535), 32'h0010_0002, 32'h0010_0006, 1, 1, 2, 1, 1);
    run("R3", mkInstr(0, 9, -65536), 32'h0010_0003, 32'h0010_0007, 1, 1, 3, 1, 0);
    run("R2", mkInstr(1, 31, -1), 32'h0000_2001, 32'h0000_2005, 1, 0, 1, 0, 0);
    run("R2", mkInstr(0, 1, 1), 32'hFFFF_FFF0, 32'hFFFF_FFF4, 1, 1, 0, 1, 2);
    // R9: zero link index suppresses write, return address wraps
    run("R9", mkInstr(1, 0, 100), 32'h0000_3003, 32'h0000_3007, 1, 1, 3, 1, 4);
    run("R9", mkInstr(0, 3, 4), 32'hFFFF_FFF9, 32'hFFFF_FFFD, 1, 1, 1, 1, 7);
    // R4: back address unknown, non-sequential, and precedence over a miss
    run("R4", mkInstr(1, 5, 12), 32'h0000_5003, 32'h0000_5007, 0, 1, 3, 1, 4);
    run("R4", mkInstr(1, 5, 12), 32'h0000_5003, 32'h0000_500B, 1, 1, 3, 1, 4);
    run("R4", mkInstr(0, 5, 12), 32'h0000_5003, 32'h0000_6003, 1, 1, 3, 0, 4);
    // R1: words outside the pattern produce nothing
    run("R1", mkInstr(1, 5, 12) & ~32'h0000_2000, 32'h0000_7003, 32'h0000_7007, 1, 1, 3, 1, 4);
    run("R1", mkInstr(1, 5, 12) ^ 32'h0400_0000, 32'h0000_7003, 32'h0000_7007, 1, 0, 3, 1, 4);
    run("R1", mkInstr(0, 5, 12) | 32'h0000_4000, 32'h0000_7003, 32'h0000_7007, 1, 0, 3, 1, 4);
    // R10: result lasts one cycle only
    run("R6", mkInstr(1, 4, 8), 32'h0000_8003, 32'h0000_8007, 1, 1, 3, 1, 4);
    @(negedge clk);
    checkAll("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule